// File: doc/BRIEF.md
# Register-Pointer Two-Wire Slave

This block is the bus-facing front end of a small peripheral that exposes a bank of sixteen byte-wide registers over a two-wire serial bus (I2C or SMBus style). It takes already synchronised clock and data lines and a configured 7-bit device address. It drives one open-drain style output, a request to pull the data line low. On the register side it presents a pointer, a write strobe with write data and a read strobe. The read data is expected combinationally from whichever register the pointer selects.

A write transfer carries the address with the direction bit clear and then a command byte. The low four bits of the command byte become the register pointer. Every byte after the command byte in the same transfer is written to the selected register. A read first sets the pointer with a short write transfer. It then issues a repeated START, the address with the direction bit set, and clocks out bytes. Registers marked read-only by a parameter mask still acknowledge writes, but the write strobe is withheld for them.

The block also answers the bus-wide general-call address. When the command byte 06h follows it and the master closes the transfer with a STOP, the block emits a one-cycle reset pulse for the whole register bank.

Top module: `i2c_regptr_slave`

## Requirements
- R1: After reset, `sda_pull`, `reg_wr`, `reg_rd` and `sw_reset` are 0 and `reg_ptr` is 0.
- R2: The first byte after a START is an address byte: bits 7..1 are the address and bit 0 is the direction (0 write, 1 read). The block acknowledges it (pulls SDA low during the ninth clock) exactly when bits 7..1 equal `dev_addr`, or when the whole byte is 00h. Any other address is not acknowledged and causes no strobe.
- R3: After a matching write address, the next byte is acknowledged and its low 4 bits are loaded into `reg_ptr`.
- R4: Each later byte of the same write transfer is acknowledged and produces one single-cycle `reg_wr` pulse, with `reg_wdata` equal to the byte. `reg_ptr` stays unchanged.
- R5: A data byte written while `reg_ptr` selects a register whose bit is set in `RO_MASK` (default 0003h, registers 0 and 1) is still acknowledged, but produces no `reg_wr` pulse.
- R6: After a matching read address, the block drives the byte `reg_rdata` of the pointed register MSB first. It pulses `reg_rd` once for each byte it loads.
- R7: A master ACK after a read byte makes the block send another byte from the same pointer. A master NACK ends the read: `sda_pull` stays 0 and no further `reg_rd` occurs until the next START.
- R8: The general-call byte 00h followed by the byte 06h gets both bytes acknowledged. At the following STOP, `sw_reset` pulses for exactly one cycle.
- R9: After the general-call address, any byte other than 06h is not acknowledged. A further byte after 06h is also not acknowledged and cancels the pending reset. In both cases no `sw_reset` pulse follows.
- R10: A START or STOP in the middle of a byte abandons the transfer without any strobe. The block then returns to address matching, so a following complete transfer works normally.
- R11: `sda_pull` only becomes asserted while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl | input | 1 | Synchronised bus clock line |
| sda | input | 1 | Synchronised bus data line (wired-AND level) |
| dev_addr | input | 7 | Configured device address |
| sda_pull | output | 1 | 1 = pull the data line low |
| reg_ptr | output | PTR_W (4) | Current register pointer |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 8 | Data for the write strobe |
| reg_rd | output | 1 | One-cycle pulse when a read byte is loaded |
| reg_rdata | input | 8 | Contents of the register selected by `reg_ptr` |
| sw_reset | output | 1 | One-cycle register bank reset pulse |

## Verification
The bench sweeps every one of the 128 addresses, so a comparator that dropped a bit or ignored the general-call code would acknowledge the wrong set. It writes and reads back all sixteen pointers. A design that wrote read-only registers or shifted read data LSB first would return wrong bytes there. Multi-byte reads and writes catch a design that moved the pointer or kept driving after a NACK. General-call sequences with the right code, a wrong code and a trailing byte expose a reset that fires too eagerly or not at all. START and STOP dropped into the middle of bytes catch a design that commits a partial byte or stays stuck out of address matching.

// File: rtl/i2c_regptr_slave.sv
module i2c_regptr_slave #(
  parameter int PTR_W = 4,
  parameter logic [(1<<PTR_W)-1:0] RO_MASK = 16'h0003,
  parameter logic [7:0] RESET_CMD = 8'h06
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl,
  input  logic             sda,
  input  logic [6:0]       dev_addr,
  output logic             sda_pull,
  output logic [PTR_W-1:0] reg_ptr,
  output logic             reg_wr,
  output logic [7:0]       reg_wdata,
  output logic             reg_rd,
  input  logic [7:0]       reg_rdata,
  output logic             sw_reset
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_WDATA, S_RDATA, S_GCALL, S_GCWAIT} st_t;

  st_t        st;
  logic       scl_q, sda_q, ack, gc_arm;
  logic [3:0] cnt;
  logic [6:0] sr;
  logic [7:0] tx;

  wire rise     = scl & ~scl_q;
  wire fall     = ~scl & scl_q;
  wire start    = scl & scl_q & sda_q & ~sda;
  wire stop     = scl & scl_q & ~sda_q & sda;
  wire [7:0] rx = {sr, sda};
  wire addr_hit = rx[7:1] == dev_addr;
  wire gc_hit   = rx == 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; scl_q <= 1'b1; sda_q <= 1'b1; ack <= 1'b0; gc_arm <= 1'b0;
      cnt <= '0; sr <= '0; tx <= '0; sda_pull <= 1'b0; reg_ptr <= '0;
      reg_wr <= 1'b0; reg_wdata <= '0; reg_rd <= 1'b0; sw_reset <= 1'b0;
    end else begin
      scl_q <= scl; sda_q <= sda;
      reg_wr <= 1'b0; reg_rd <= 1'b0; sw_reset <= 1'b0;
      if (start) begin
        st <= S_ADDR; cnt <= '0; sda_pull <= 1'b0; gc_arm <= 1'b0; ack <= 1'b0;
      end else if (stop) begin
        st <= S_IDLE; sda_pull <= 1'b0; sw_reset <= gc_arm; gc_arm <= 1'b0;
      end else if (st != S_IDLE) begin
        if (rise) begin
          if (cnt != 4'd8) begin
            sr  <= rx[6:0];
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              case (st)
                S_ADDR: begin
                  if (addr_hit) begin ack <= 1'b1; st <= rx[0] ? S_RDATA : S_CMD; end
                  else if (gc_hit) begin ack <= 1'b1; st <= S_GCALL; end
                  else begin ack <= 1'b0; st <= S_IDLE; end
                end
                S_CMD: begin ack <= 1'b1; reg_ptr <= rx[PTR_W-1:0]; st <= S_WDATA; end
                S_WDATA: begin ack <= 1'b1; reg_wdata <= rx; reg_wr <= ~RO_MASK[reg_ptr]; end
                S_GCALL: begin
                  if (rx == RESET_CMD) begin ack <= 1'b1; gc_arm <= 1'b1; st <= S_GCWAIT; end
                  else begin ack <= 1'b0; st <= S_IDLE; end
                end
                S_GCWAIT: begin ack <= 1'b0; gc_arm <= 1'b0; st <= S_IDLE; end
                default: ack <= 1'b0;
              endcase
            end
          end else begin
            cnt <= '0;
            if (st == S_RDATA) begin
              if (ack || !sda) begin tx <= reg_rdata; reg_rd <= 1'b1; end
              else st <= S_IDLE;
            end
          end
        end else if (fall) begin
          if (cnt == 4'd8)         sda_pull <= ack;
          else if (st == S_RDATA)  sda_pull <= ~tx[3'd7 - cnt[2:0]];
          else                     sda_pull <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/i2c_regptr_slave_chk.sv
module i2c_regptr_slave_chk #(
  parameter int PTR_W = 4,
  parameter logic [(1<<PTR_W)-1:0] RO_MASK = 16'h0003
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl,
  input logic             sda,
  input logic             sda_pull,
  input logic [PTR_W-1:0] reg_ptr,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic             sw_reset
);

  assert_pull_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl);

  assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  assert_ptr_stable_on_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> $stable(reg_ptr));

  assert_no_ro_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !RO_MASK[reg_ptr]);

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  assert_rd_while_scl_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> scl);

  assert_rst_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> !sw_reset);

  assert_rst_at_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |-> (scl && sda));

endmodule

bind i2c_regptr_slave i2c_regptr_slave_chk #(.PTR_W(PTR_W), .RO_MASK(RO_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda), .sda_pull(sda_pull),
  .reg_ptr(reg_ptr), .reg_wr(reg_wr), .reg_rd(reg_rd), .sw_reset(sw_reset)
);

// File: tb/i2c_regptr_slave_bench.sv
module i2c_regptr_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] DEV = 7'h25;
  localparam logic [15:0] RO = 16'h0003;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_pull, reg_wr, reg_rd, sw_reset;
  logic [3:0] reg_ptr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [16];
  wire sda = sda_m & ~sda_pull;
  int checks = 0, errors = 0, n_wr = 0, n_rd = 0, n_rst = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_regptr_slave u_i2c_regptr_slave (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda), .dev_addr(DEV),
    .sda_pull(sda_pull), .reg_ptr(reg_ptr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .sw_reset(sw_reset)
  );

  function automatic logic [7:0] dflt(int p);
    return 8'(p * 37 + 5);
  endfunction

  assign reg_rdata = mem[reg_ptr];
  always @(posedge clk) begin
    if (!rst_n || sw_reset) begin
      for (int i = 0; i < 16; i++) mem[i] <= dflt(i);
    end else if (reg_wr) mem[reg_ptr] <= reg_wdata;
  end

  always @(negedge clk) begin
    if (reg_wr) n_wr++;
    if (reg_rd) n_rd++;
    if (sw_reset) n_rst++;
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    sda_m = 1'b1; w(2); scl = 1'b1; w(4); sda_m = 1'b0; w(4); scl = 1'b0; w(2);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; w(2); scl = 1'b1; w(4); sda_m = 1'b1; w(4);
  endtask

  task automatic put_bit(logic b);
    sda_m = b; w(4); scl = 1'b1; w(4); scl = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; w(4); scl = 1'b1; w(2); ack = ~sda; w(2); scl = 1'b0;
  endtask

  task automatic get_byte(logic mack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; w(4); scl = 1'b1; w(2); b = {b[6:0], sda}; w(2); scl = 1'b0;
    end
    sda_m = ~mack; w(4); scl = 1'b1; w(4); scl = 1'b0;
    sda_m = 1'b1;
  endtask

  task automatic wr_reg(logic [3:0] p, logic [7:0] v);
    logic a;
    bus_start;
    send_byte({DEV, 1'b0}, a); check(a, "R2 write address ack", a, 1);
    send_byte({4'h0, p}, a);   check(a, "R3 command ack", a, 1);
    send_byte(v, a);           check(a, "R4 data ack", a, 1);
    bus_stop;
  endtask

  task automatic rd_reg(logic [3:0] p, output logic [7:0] v);
    logic a;
    bus_start;
    send_byte({DEV, 1'b0}, a);
    send_byte({4'h0, p}, a);
    bus_start;
    send_byte({DEV, 1'b1}, a); check(a, "R6 read address ack", a, 1);
    get_byte(1'b0, v);
    bus_stop;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end

  initial begin
    logic a;
    logic [7:0] v, v2;
    int base_wr, base_rd, base_rst;
    w(5); rst_n = 1'b1; w(3);
    // R1 reset state
    check(sda_pull == 0 && reg_wr == 0 && reg_rd == 0 && sw_reset == 0, "R1 outputs idle",
          {sda_pull, reg_wr, reg_rd, sw_reset}, 0);
    check(reg_ptr == 0, "R1 pointer", reg_ptr, 0);

    // R2 full address sweep
    base_wr = n_wr; base_rd = n_rd; base_rst = n_rst;
    for (int ad = 0; ad < 128; ad++) begin
      bus_start;
      send_byte({7'(ad), 1'b0}, a);
      bus_stop;
      check(a == (ad == DEV || ad == 0), "R2 address ack", a, (ad == DEV || ad == 0));
    end
    check(n_wr == base_wr && n_rd == base_rd && n_rst == base_rst, "R2 no strobes",
          n_wr + n_rd + n_rst, base_wr + base_rd + base_rst);

    // R3 R4 R5 R6 pointer sweep with readback
    for (int p = 0; p < 16; p++) begin
      base_wr = n_wr;
      v2 = 8'(p * 11) ^ 8'hA5;
      wr_reg(4'(p), v2);
      check(reg_ptr == 4'(p), "R3 pointer load", reg_ptr, p);
      check(n_wr - base_wr == (RO[p] ? 0 : 1), RO[p] ? "R5 read-only no strobe" : "R4 write strobe",
            n_wr - base_wr, RO[p] ? 0 : 1);
      base_rd = n_rd;
      rd_reg(4'(p), v);
      check(v == (RO[p] ? dflt(p) : v2), "R6 readback", v, RO[p] ? dflt(p) : v2);
      check(n_rd - base_rd == 1, "R6 read strobe count", n_rd - base_rd, 1);
    end

    // R4 multi-byte write keeps the pointer
    base_wr = n_wr;
    bus_start;
    send_byte({DEV, 1'b0}, a);
    send_byte(8'hF5, a);
    check(reg_ptr == 4'd5, "R3 low nibble only", reg_ptr, 5);
    for (int k = 0; k < 3; k++) begin
      send_byte(8'h40 + 8'(k), a);
      check(a, "R4 burst ack", a, 1);
    end
    bus_stop;
    check(n_wr - base_wr == 3, "R4 burst strobes", n_wr - base_wr, 3);
    rd_reg(4'd5, v);
    check(v == 8'h42, "R4 last burst byte", v, 8'h42);

    // R7 read with master ACK then NACK
    wr_reg(4'd7, 8'h96);
    base_rd = n_rd;
    bus_start;
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h07, a);
    bus_start;
    send_byte({DEV, 1'b1}, a);
    get_byte(1'b1, v);
    check(v == 8'h96, "R7 first byte", v, 8'h96);
    get_byte(1'b0, v);
    check(v == 8'h96, "R7 second byte", v, 8'h96);
    w(20);
    check(sda_pull == 0, "R7 released after NACK", sda_pull, 0);
    bus_stop;
    check(n_rd - base_rd == 2, "R7 read strobes", n_rd - base_rd, 2);

    // R8 general-call reset
    wr_reg(4'd9, 8'h3C);
    base_rst = n_rst;
    bus_start;
    send_byte(8'h00, a); check(a, "R8 general call ack", a, 1);
    send_byte(8'h06, a); check(a, "R8 reset code ack", a, 1);
    check(n_rst == base_rst, "R8 no reset before STOP", n_rst - base_rst, 0);
    bus_stop; w(2);
    check(n_rst - base_rst == 1, "R8 one reset pulse", n_rst - base_rst, 1);
    rd_reg(4'd9, v);
    check(v == dflt(9), "R8 register restored", v, dflt(9));

    // R9 wrong code, and trailing byte
    base_rst = n_rst;
    bus_start;
    send_byte(8'h00, a);
    send_byte(8'h07, a); check(!a, "R9 wrong code NACK", a, 0);
    bus_stop;
    bus_start;
    send_byte(8'h00, a);
    send_byte(8'h06, a);
    send_byte(8'h06, a); check(!a, "R9 trailing byte NACK", a, 0);
    bus_stop; w(2);
    check(n_rst == base_rst, "R9 no reset", n_rst - base_rst, 0);

    // R10 STOP mid data byte, START mid address byte
    wr_reg(4'd10, 8'h11);
    base_wr = n_wr;
    bus_start;
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h0A, a);
    for (int i = 0; i < 5; i++) put_bit(i[0]);
    bus_stop;
    check(n_wr == base_wr, "R10 no strobe on abort", n_wr - base_wr, 0);
    rd_reg(4'd10, v);
    check(v == 8'h11, "R10 register intact", v, 8'h11);
    bus_start;
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    wr_reg(4'd10, 8'h22);
    rd_reg(4'd10, v);
    check(v == 8'h22, "R10 recovery after restart", v, 8'h22);

    w(10);
    finish_run;
  end
endmodule